// File: doc/BRIEF.md
# Life-Cycle Transition Sequencer

This block is the control machine that carries out one requested change of a device's life-cycle state. After reset it settles in an idle state and waits for a request. An accepted request walks a fixed chain of steps: switch the clock source, test and bump the transition counter, have the external one-time-programmable store write the counter, check that the requested transition is legal, have an external hasher turn the supplied token into a hashed value, optionally wipe flash, compare the hashed token against the expected value in two back-to-back stages, and finally program the new state. Each step that can fail has its own exit to a post-transition state. That state holds until reset.

Two independent escalation inputs override everything. Either one forces a terminal escalate state from any state. The escalate state holds until reset. The state register uses a sparse code, so a single flipped bit can never turn one legal state into another. Any unlisted value is decoded as the invalid state, which escalates on the next cycle. The hashing, OTP storage and flash logic are outside the block and are reached through simple request/acknowledge handshakes.

Top module: `lc_xfer_seq`

## Requirements
- R1: A synchronous active-low reset puts the sequencer in RESET. `state_o` shows the state as a 7-bit code. For state index i (RESET 0, IDLE 1, CLKMUX 2, CNTINC 3, CNTPROG 4, TCHK 5, HASH 6, WIPE 7, TOK0 8, TOK1 9, TPROG 10, POST 11, SCRAP 12, ESC 13, INVALID 14) with bits d3..d0, the code is {d3,d2,d1,d0,d1^d2^d3,d0^d2^d3,d0^d1^d3} XOR 7'b0101010.
- R2: RESET always moves to IDLE on the next cycle.
- R3: In IDLE, `lc_scrap_i` high moves to SCRAP, even when a request is present. Otherwise `xfer_req_i` high moves to CLKMUX. Otherwise the sequencer stays in IDLE. SCRAP holds until escalation or reset.
- R4: CLKMUX always moves to CNTINC. CNTINC moves to POST when `cnt_sat_i` is high and to CNTPROG otherwise.
- R5: CNTPROG raises `otp_req_o` with `otp_tgt_o`=0 and stays until `otp_ack_i`. On the acknowledge it moves to POST if `otp_err_i` is high and to TCHK otherwise.
- R6: TCHK moves to HASH when `trans_ok_i` is high and to POST otherwise.
- R7: HASH raises `hash_req_o` and stays until `hash_ack_i`. On the acknowledge it moves to POST if `hash_err_i` is high. Otherwise it captures `hash_tok_i` and moves to WIPE.
- R8: WIPE moves to TOK0 at once when `wipe_en_i` is low. When `wipe_en_i` is high it raises `wipe_req_o` and stays until `wipe_ack_i`.
- R9: TOK0 moves to TOK1 when the captured token equals `exp_tok_i` and to POST otherwise. TOK1 moves to TPROG only when both the TOK0 compare and its own compare matched, and to POST otherwise. TOK1 never lasts two cycles.
- R10: TPROG raises `otp_req_o` with `otp_tgt_o`=1 and stays until `otp_ack_i`. It then moves to POST whatever `otp_err_i` shows.
- R11: POST holds until escalation or reset.
- R12: When `esc_a_i` or `esc_b_i` is high, the next state is ESC, from every state. ESC holds until reset. A register value that is no legal code behaves as INVALID, which moves to ESC.
- R13: `clk_sw_o` is high exactly in CLKMUX through TPROG. In ESC, SCRAP and INVALID, every request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| esc_a_i | input | 1 | First escalation input |
| esc_b_i | input | 1 | Second escalation input |
| xfer_req_i | input | 1 | Transition request, sampled in IDLE |
| lc_scrap_i | input | 1 | Current life-cycle state is a scrap or invalid one |
| cnt_sat_i | input | 1 | Transition counter is saturated |
| trans_ok_i | input | 1 | Requested transition is legal |
| otp_req_o | output | 1 | Programming request to the OTP programmer |
| otp_tgt_o | output | 1 | Programming target: 0 counter, 1 state |
| otp_ack_i | input | 1 | Programmer acknowledge |
| otp_err_i | input | 1 | Programmer error, valid with acknowledge |
| hash_req_o | output | 1 | Token hash request |
| hash_ack_i | input | 1 | Hasher acknowledge |
| hash_err_i | input | 1 | Hasher error, valid with acknowledge |
| hash_tok_i | input | TOKEN_W | Hashed token, valid with acknowledge |
| wipe_en_i | input | 1 | Flash wipe wanted for this transition |
| wipe_req_o | output | 1 | Flash wipe request |
| wipe_ack_i | input | 1 | Flash wipe acknowledge |
| exp_tok_i | input | TOKEN_W | Expected hashed token |
| clk_sw_o | output | 1 | Clock switched for the transition |
| state_o | output | 7 | Encoded sequencer state |

## Verification
The bench builds the block with TOKEN_W set to 16. This keeps the token path narrow, so random token values and single-bit corruptions of the expected token are cheap to produce. The same compare logic is used at the 64-bit default. With this width, both compare stages can be made to match or to miss on chosen cycles, so the step from TOK1 to TPROG and the failure exits from TOK0 and TOK1 are all reached. The escalate and reset rates are set low enough for complete transitions to finish between them. They are still high enough for escalation to hit every intermediate state.

// File: rtl/lcseq_pkg.sv
// Package: state indices and the sparse state code shared by the sequencer.
// Assumes: 15 states; codes are a distance-3 linear code XORed with a mask.
package lcseq_pkg;

    localparam int STATE_W = 7;
    localparam int NUM_ST  = 15;

    typedef enum logic [3:0] {
        S_RESET   = 4'd0,
        S_IDLE    = 4'd1,
        S_CLKMUX  = 4'd2,
        S_CNTINC  = 4'd3,
        S_CNTPROG = 4'd4,
        S_TCHK    = 4'd5,
        S_HASH    = 4'd6,
        S_WIPE    = 4'd7,
        S_TOK0    = 4'd8,
        S_TOK1    = 4'd9,
        S_TPROG   = 4'd10,
        S_POST    = 4'd11,
        S_SCRAP   = 4'd12,
        S_ESC     = 4'd13,
        S_INVALID = 4'd14
    } lcseq_idx_e;

    // Maps a state index to its 7-bit protected code.
    function automatic logic [STATE_W-1:0] lcseq_code(input logic [3:0] d);
        logic [2:0] p;
        p[0] = d[0] ^ d[1] ^ d[3];
        p[1] = d[0] ^ d[2] ^ d[3];
        p[2] = d[1] ^ d[2] ^ d[3];
        return {d, p} ^ 7'b0101010;
    endfunction

endpackage

// File: rtl/lcseq_state_dec.sv
// Module: lcseq_state_dec
// Turns the raw state register into a state index.
// Assumes: any value that matches no legal code stands for INVALID.
module lcseq_state_dec
    import lcseq_pkg::*;
(
    input  logic [STATE_W-1:0] code_i,
    output lcseq_idx_e         idx_o
);

    // Compares the register against every legal code.
    always_comb begin
        idx_o = S_INVALID;
        for (int k = 0; k < NUM_ST; k++) begin
            if (code_i == lcseq_code(4'(k))) begin
                idx_o = lcseq_idx_e'(k);
            end
        end
    end

endmodule

// File: rtl/lcseq_tok_store.sv
// Module: lcseq_tok_store
// Keeps two copies of the hashed token and the result of the first compare.
// Assumes: cap_i pulses for one cycle when the hasher returns a good token.
module lcseq_tok_store #(
    parameter int TOKEN_W = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cap_i,
    input  logic [TOKEN_W-1:0] tok_i,
    input  logic [TOKEN_W-1:0] exp_i,
    input  logic               stage0_i,
    output logic               match0_o,
    output logic               match_both_o
);

    logic [TOKEN_W-1:0] tok_a_q, tok_b_q;
    logic               m0_q;

    // Captures the hashed token into both copies.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tok_a_q <= '0;
            tok_b_q <= '0;
        end else if (cap_i) begin
            tok_a_q <= tok_i;
            tok_b_q <= tok_i;
        end
    end

    // Records the first-stage compare result while in TOK0.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            m0_q <= 1'b0;
        end else if (stage0_i) begin
            m0_q <= match0_o;
        end
    end

    // Each stage compares its own copy against the expected token.
    assign match0_o     = (tok_a_q == exp_i);
    assign match_both_o = m0_q && (tok_b_q == exp_i);

endmodule

// File: rtl/lcseq_next.sv
// Module: lcseq_next
// Combinational next-state logic of the transition sequencer.
// Assumes: escalation outranks every other condition; INVALID always escalates.
module lcseq_next
    import lcseq_pkg::*;
(
    input  lcseq_idx_e idx_i,
    input  logic       esc_i,
    input  logic       req_i,
    input  logic       scrap_i,
    input  logic       sat_i,
    input  logic       trans_ok_i,
    input  logic       otp_ack_i,
    input  logic       otp_err_i,
    input  logic       hash_ack_i,
    input  logic       hash_err_i,
    input  logic       wipe_en_i,
    input  logic       wipe_ack_i,
    input  logic       match0_i,
    input  logic       match_both_i,
    output lcseq_idx_e nxt_o,
    output logic       cap_o
);

    // Chooses the successor state for every step of the sequence.
    always_comb begin
        nxt_o = idx_i;
        case (idx_i)
            S_RESET:   nxt_o = S_IDLE;
            S_IDLE: begin
                if (scrap_i)    nxt_o = S_SCRAP;
                else if (req_i) nxt_o = S_CLKMUX;
            end
            S_CLKMUX:  nxt_o = S_CNTINC;
            S_CNTINC:  nxt_o = sat_i ? S_POST : S_CNTPROG;
            S_CNTPROG: if (otp_ack_i) nxt_o = otp_err_i ? S_POST : S_TCHK;
            S_TCHK:    nxt_o = trans_ok_i ? S_HASH : S_POST;
            S_HASH:    if (hash_ack_i) nxt_o = hash_err_i ? S_POST : S_WIPE;
            S_WIPE:    if (!wipe_en_i || wipe_ack_i) nxt_o = S_TOK0;
            S_TOK0:    nxt_o = match0_i ? S_TOK1 : S_POST;
            S_TOK1:    nxt_o = match_both_i ? S_TPROG : S_POST;
            S_TPROG:   if (otp_ack_i) nxt_o = S_POST;
            S_POST, S_SCRAP, S_ESC: nxt_o = idx_i;
            default:   nxt_o = S_ESC;
        endcase
        if (esc_i) nxt_o = S_ESC;
    end

    // Flags a successful hash return for token capture.
    assign cap_o = (idx_i == S_HASH) && hash_ack_i && !hash_err_i && !esc_i;

endmodule

// File: rtl/lc_xfer_seq.sv
// Module: lc_xfer_seq (top)
// Sequences one life-cycle state transition through external handshakes.
// Assumes: ack/err/token inputs are synchronous to clk_i; err is valid with ack.
module lc_xfer_seq
    import lcseq_pkg::*;
#(
    parameter int TOKEN_W = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               esc_a_i,
    input  logic               esc_b_i,
    input  logic               xfer_req_i,
    input  logic               lc_scrap_i,
    input  logic               cnt_sat_i,
    input  logic               trans_ok_i,
    output logic               otp_req_o,
    output logic               otp_tgt_o,
    input  logic               otp_ack_i,
    input  logic               otp_err_i,
    output logic               hash_req_o,
    input  logic               hash_ack_i,
    input  logic               hash_err_i,
    input  logic [TOKEN_W-1:0] hash_tok_i,
    input  logic               wipe_en_i,
    output logic               wipe_req_o,
    input  logic               wipe_ack_i,
    input  logic [TOKEN_W-1:0] exp_tok_i,
    output logic               clk_sw_o,
    output logic [6:0]         state_o
);

    logic [STATE_W-1:0] state_q;
    lcseq_idx_e         idx, nxt;
    logic               cap, match0, match_both;

    lcseq_state_dec u_dec (
        .code_i (state_q),
        .idx_o  (idx)
    );

    lcseq_tok_store #(.TOKEN_W(TOKEN_W)) u_tok (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cap_i        (cap),
        .tok_i        (hash_tok_i),
        .exp_i        (exp_tok_i),
        .stage0_i     (idx == S_TOK0),
        .match0_o     (match0),
        .match_both_o (match_both)
    );

    lcseq_next u_next (
        .idx_i        (idx),
        .esc_i        (esc_a_i | esc_b_i),
        .req_i        (xfer_req_i),
        .scrap_i      (lc_scrap_i),
        .sat_i        (cnt_sat_i),
        .trans_ok_i   (trans_ok_i),
        .otp_ack_i    (otp_ack_i),
        .otp_err_i    (otp_err_i),
        .hash_ack_i   (hash_ack_i),
        .hash_err_i   (hash_err_i),
        .wipe_en_i    (wipe_en_i),
        .wipe_ack_i   (wipe_ack_i),
        .match0_i     (match0),
        .match_both_i (match_both),
        .nxt_o        (nxt),
        .cap_o        (cap)
    );

    // Holds the protected state code.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= lcseq_code(S_RESET);
        else         state_q <= lcseq_code(nxt);
    end

    // Drives the handshake requests and the clock switch from the state.
    always_comb begin
        otp_req_o  = (idx == S_CNTPROG) || (idx == S_TPROG);
        otp_tgt_o  = (idx == S_TPROG);
        hash_req_o = (idx == S_HASH);
        wipe_req_o = (idx == S_WIPE) && wipe_en_i;
        clk_sw_o   = (idx >= S_CLKMUX) && (idx <= S_TPROG);
    end

    assign state_o = state_q;

endmodule

// File: rtl/lcseq_chk.sv
// Module: lcseq_chk
// Temporal checks on the sequencer ports, attached to every lc_xfer_seq.
// Assumes: the state code mapping from lcseq_pkg.
module lcseq_chk
    import lcseq_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       esc_a_i,
    input logic       esc_b_i,
    input logic [6:0] state_o,
    input logic       otp_req_o,
    input logic       hash_req_o,
    input logic       wipe_req_o
);

    logic esc, legal;
    assign esc = esc_a_i | esc_b_i;

    // Legality of the observed code, from the package mapping.
    always_comb begin
        legal = 1'b0;
        for (int k = 0; k < NUM_ST; k++) begin
            if (state_o == lcseq_code(4'(k))) legal = 1'b1;
        end
    end

    AST_ESC_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        esc |=> state_o == lcseq_code(S_ESC)); // R12
    AST_ESC_ABSORBS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == lcseq_code(S_ESC) |=> state_o == lcseq_code(S_ESC)); // R12
    AST_ILLEGAL_ESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !legal |=> state_o == lcseq_code(S_ESC)); // R12
    AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == lcseq_code(S_RESET) && !esc) |=> state_o == lcseq_code(S_IDLE)); // R2
    AST_TOK1_NO_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == lcseq_code(S_TOK1) |=> state_o != lcseq_code(S_TOK1)); // R9
    AST_TPROG_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == lcseq_code(S_TPROG) && !$stable(state_o))
            |-> $past(state_o) == lcseq_code(S_TOK1)); // R9
    AST_POST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == lcseq_code(S_POST) && !esc) |=> state_o == lcseq_code(S_POST)); // R11
    AST_QUIET_TERMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == lcseq_code(S_ESC) || state_o == lcseq_code(S_SCRAP)
            || state_o == lcseq_code(S_INVALID))
            |-> !(otp_req_o || hash_req_o || wipe_req_o)); // R13

endmodule

bind lc_xfer_seq lcseq_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .esc_a_i    (esc_a_i),
    .esc_b_i    (esc_b_i),
    .state_o    (state_o),
    .otp_req_o  (otp_req_o),
    .hash_req_o (hash_req_o),
    .wipe_req_o (wipe_req_o)
);

// File: tb/lc_xfer_seq_test.sv
// Bench: random handshake responders plus directed corner cases, checked
// cycle by cycle against a state model built from the requirements.
module lc_xfer_seq_test;

    localparam int TW = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, esc_a, esc_b, req, scrap, sat, tok_ok;
    logic otp_ack, otp_err, hash_ack, hash_err, wipe_en, wipe_ack;
    logic [TW-1:0] hash_tok, exp_tok;
    logic otp_req, otp_tgt, hash_req, wipe_req, clk_sw;
    logic [6:0] state;

    lc_xfer_seq #(.TOKEN_W(TW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .esc_a_i(esc_a), .esc_b_i(esc_b),
        .xfer_req_i(req), .lc_scrap_i(scrap), .cnt_sat_i(sat),
        .trans_ok_i(tok_ok), .otp_req_o(otp_req), .otp_tgt_o(otp_tgt),
        .otp_ack_i(otp_ack), .otp_err_i(otp_err), .hash_req_o(hash_req),
        .hash_ack_i(hash_ack), .hash_err_i(hash_err), .hash_tok_i(hash_tok),
        .wipe_en_i(wipe_en), .wipe_req_o(wipe_req), .wipe_ack_i(wipe_ack),
        .exp_tok_i(exp_tok), .clk_sw_o(clk_sw), .state_o(state)
    );

    int n_chk = 0, n_bad = 0;
    int ex = 0;           // expected state index
    string tag = "R1";    // requirement governing the latest transition
    logic [TW-1:0] cap = '0;
    logic m0 = 1'b0;

    // Expected code for a state index, per R1.
    function automatic logic [6:0] enc(input int i);
        logic [3:0] d;
        d = 4'(i);
        return {d, d[1]^d[2]^d[3], d[0]^d[2]^d[3], d[0]^d[1]^d[3]} ^ 7'h2A;
    endfunction

    // Requirement that governs leaving a given state.
    function automatic string tag_of(input int i);
        case (i)
            0: return "R2";   1: return "R3";   2, 3: return "R4";
            4: return "R5";   5: return "R6";   6: return "R7";
            7: return "R8";   8, 9: return "R9"; 10: return "R10";
            11: return "R11"; 12: return "R3";  default: return "R12";
        endcase
    endfunction

    // Next state expected from the requirements.
    function automatic int model_next(input int s);
        int n;
        n = s;
        case (s)
            0: n = 1;
            1: n = scrap ? 12 : (req ? 2 : 1);
            2: n = 3;
            3: n = sat ? 11 : 4;
            4: if (otp_ack) n = otp_err ? 11 : 5;
            5: n = tok_ok ? 6 : 11;
            6: if (hash_ack) n = hash_err ? 11 : 7;
            7: if (!wipe_en || wipe_ack) n = 8;
            8: n = (cap == exp_tok) ? 9 : 11;
            9: n = (m0 && cap == exp_tok) ? 10 : 11;
            10: if (otp_ack) n = 11;
            default: n = s;
        endcase
        if (esc_a || esc_b) n = 13;
        return n;
    endfunction

    // Drives one cycle of inputs; good=1 removes faults and escalation.
    task automatic drive(input bit good);
        rst_n    = good ? 1'b1 : ($urandom % 400 != 0);
        esc_a    = good ? 1'b0 : ($urandom % 150 == 0);
        esc_b    = good ? 1'b0 : ($urandom % 150 == 0);
        scrap    = good ? 1'b0 : ($urandom % 20 == 0);
        req      = ($urandom % 3 == 0);
        sat      = good ? 1'b0 : ($urandom % 10 == 0);
        tok_ok   = good ? 1'b1 : ($urandom % 8 != 0);
        otp_ack  = $urandom % 2;
        otp_err  = good ? 1'b0 : ($urandom % 8 == 0);
        hash_ack = $urandom % 2;
        hash_err = good ? 1'b0 : ($urandom % 10 == 0);
        hash_tok = TW'($urandom);
        wipe_en  = $urandom % 2;
        wipe_ack = $urandom % 2;
        exp_tok  = (good || $urandom % 5 != 0) ? cap : cap ^ (TW'(1) << ($urandom % TW));
    endtask

    // Compares outputs for the current state, then advances the model.
    task automatic step_check();
        #1;
        n_chk++;
        if (state !== enc(ex)) begin
            n_bad++;
            $display("FAIL %s state: got %h expected %h", tag, state, enc(ex));
        end
        n_chk++;
        if (otp_req !== (ex == 4 || ex == 10) || otp_tgt !== (ex == 10)
            || hash_req !== (ex == 6) || wipe_req !== (ex == 7 && wipe_en)
            || clk_sw !== (ex >= 2 && ex <= 10)) begin
            n_bad++;
            $display("FAIL R13 outputs in state %0d: got %b%b%b%b%b expected %b%b%b%b%b",
                ex, otp_req, otp_tgt, hash_req, wipe_req, clk_sw,
                (ex == 4 || ex == 10), (ex == 10), (ex == 6),
                (ex == 7 && wipe_en), (ex >= 2 && ex <= 10));
        end
        if (!rst_n) begin
            ex = 0; tag = "R1"; cap = '0; m0 = 1'b0;
        end else begin
            int nx;
            nx = model_next(ex);
            tag = (esc_a || esc_b) ? "R12" : tag_of(ex);
            if (ex == 8) m0 = (cap == exp_tok);
            if (ex == 6 && hash_ack && !hash_err && !(esc_a || esc_b)) cap = hash_tok;
            ex = nx;
        end
    endtask

    initial begin
        void'($urandom(32'h5EC0_0D1E));
        drive(1'b1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state code
        ex = 0; tag = "R1";
        step_check();
        // R12: escalation out of the RESET state, then absorbing
        @(negedge clk); drive(1'b1); esc_b = 1'b1; step_check();
        @(negedge clk); drive(1'b1); step_check();
        @(negedge clk); drive(1'b1); step_check();
        @(negedge clk); drive(1'b1); rst_n = 1'b0; step_check();
        // R9/R10: fault-free phase with periodic resets reaches TPROG
        for (int c = 0; c < 600; c++) begin
            @(negedge clk); drive(1'b1);
            if (c % 60 == 59) rst_n = 1'b0;
            step_check();
        end
        // Random phase: faults, scrap, escalation and resets
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk); drive(1'b0); step_check();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule